// File: doc/BRIEF.md
# Trace-Sum Correlation Statistics Accumulator

This block gathers the running statistics needed to rank 256 key-byte guesses by correlation against measured power traces when the leakage inside each trace lands at an unpredictable time. Every trace arrives as a stream of signed samples framed by start and end markers. The block reduces each trace to one figure, the total of all its samples, with no attempt to align samples in time. The known ciphertext byte for the trace travels with the closing sample.

When a trace closes, the block walks through the guesses 0 to 255 in ascending order. For each guess it asks an external hypothesis source for the leakage prediction of that guess and that ciphertext byte, and folds the answer into per-guess sums that are held in a block RAM. It also keeps shared sums across all traces: the trace count, the sum of trace figures, and the sum of their squares.

A checkpoint request freezes the statistics and scans all 256 guesses. The scan reports the guess with the smallest signed covariance numerator, together with the sums a downstream unit needs to finish the Pearson coefficient. The smallest value wins because the measured quantity is a supply voltage: more power draw gives a lower reading, so the correct guess correlates negatively. Each key byte is attacked in its own run, separated by a clear.

Top module: `trace_corr_accum`

## Requirements
- R1: A trace's figure P is the exact signed sum of every accepted sample from the beat marked first up to and including the beat marked last. A beat marked both first and last forms a one-sample trace.
- R2: Each closed trace adds one to the trace count n, adds P to ΣP and adds P² to ΣP². All three are exact for up to 100,000 traces of up to 65,536 samples each.
- R3: After a trace closes, the block issues exactly 256 hypothesis requests, for guesses 0, 1, …, 255 in order. Each request carries the ciphertext byte presented with that trace's last sample. A request stays asserted with a stable guess until the cycle in which the response is valid.
- R4: For every guess g with response H, the stored sums are updated as ΣH_g += H, ΣH_g² += H² and ΣPH_g += P·H, all exact.
- R5: `s_ready` is low from the cycle after a trace's last sample is accepted until all 256 updates are written. No sample is accepted during that time.
- R6: A checkpoint selects the guess with the minimum signed metric n·ΣPH_g − ΣP·ΣH_g. On a tie, the lower guess index is selected.
- R7: A checkpoint result is presented with `ckpt_done` high for exactly one cycle. It carries the selected guess, its metric, n, ΣP, ΣP², and that guess's ΣH, ΣH² and ΣPH. The report reflects every trace closed before the scan began.
- R8: Reset or `clr` zeroes the trace count, the shared sums and all 256 per-guess rows, drops any open trace and any pending checkpoint, and holds `s_ready` low while the rows are being cleared.
- R9: A sample that arrives while no trace is open and is not marked first is discarded. A first-marked sample arriving while a trace is open discards the partial sum and starts a new trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all statistics |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Block can accept a sample beat |
| s_data | input | 12 | Signed two's-complement sample |
| s_first | input | 1 | Beat opens a trace |
| s_last | input | 1 | Beat closes a trace |
| s_ct | input | 8 | Ciphertext byte, taken with the closing beat |
| hyp_req_valid | output | 1 | Hypothesis request pending |
| hyp_req_guess | output | 8 | Guess value of the request |
| hyp_req_ct | output | 8 | Ciphertext byte of the request |
| hyp_rsp_valid | input | 1 | Hypothesis response valid; completes the request |
| hyp_rsp_value | input | 8 | Unsigned hypothesis value H |
| ckpt_req | input | 1 | Checkpoint request pulse |
| ckpt_done | output | 1 | One-cycle report strobe |
| ckpt_guess | output | 8 | Selected guess |
| ckpt_metric | output | 73 | Signed metric of the selected guess |
| ckpt_count | output | 17 | Trace count n |
| ckpt_sum_p | output | 45 | Signed ΣP |
| ckpt_sum_p2 | output | 73 | ΣP² |
| ckpt_sum_h | output | 25 | ΣH of the selected guess |
| ckpt_sum_h2 | output | 33 | ΣH² of the selected guess |
| ckpt_sum_ph | output | 54 | Signed ΣPH of the selected guess |

## Verification
The assertions watch properties that must hold on every cycle. The input must be blocked whenever a hypothesis request is open. A request must hold its guess until it is answered. The report strobe must last a single cycle and never overlap a request. A clear must drop the ready signal on the next cycle. The trace count may only step up by one or return to zero. The arithmetic itself can only be shown by the bench scenarios, which compare against sums computed in the bench. Those scenarios cover the exact sums, the minimum-and-tie ranking rule, the ordering of the hypothesis requests, the discarding of stray and restarted samples, a checkpoint deferred behind an open trace, and the effect of a clear.

// File: rtl/trace_corr_pkg.sv
package trace_corr_pkg;

  // Sequencer phases of the accumulator
  typedef enum logic [2:0] {
    ST_CLR,   // zeroing the per-guess rows
    ST_IDLE,  // taking samples
    ST_URD,   // update sweep: address row
    ST_UREQ,  // update sweep: wait for hypothesis
    ST_UWR,   // update sweep: write row
    ST_RRD,   // ranking scan: address row
    ST_REV,   // ranking scan: evaluate row
    ST_RFIN   // ranking scan: publish report
  } acc_state_e;

endpackage

// File: rtl/trace_sum_unit.sv
// Folds one framed sample stream into a single signed trace total.
module trace_sum_unit #(
  parameter int SAMPLE_W = 12,
  parameter int SUM_W    = 28,
  parameter int CT_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       take,
  input  logic [SAMPLE_W-1:0]        data,
  input  logic                       first,
  input  logic                       last,
  input  logic [CT_W-1:0]            ct,
  output logic                       open_o,
  output logic                       done_o,
  output logic signed [SUM_W-1:0]    sum_o,
  output logic [CT_W-1:0]            ct_o
);

  logic signed [SUM_W-1:0] acc_q;
  logic signed [SUM_W-1:0] data_x;
  logic signed [SUM_W-1:0] nxt;

  assign data_x = {{(SUM_W-SAMPLE_W){data[SAMPLE_W-1]}}, data};
  assign nxt    = (first ? '0 : acc_q) + data_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      open_o <= 1'b0;
      done_o <= 1'b0;
      sum_o  <= '0;
      ct_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (take && (first || open_o)) begin
        if (last) begin
          done_o <= 1'b1;
          sum_o  <= nxt;
          ct_o   <= ct;
          open_o <= 1'b0;
        end else begin
          acc_q  <= nxt;
          open_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/corr_row_ram.sv
// Simple dual-port RAM with registered read, shaped for block RAM inference.
module corr_row_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 112
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/corr_rank_unit.sv
// Computes the covariance numerator of one row and keeps the running minimum.
module corr_rank_unit #(
  parameter int CNT_W   = 17,
  parameter int SP_W    = 45,
  parameter int SH_W    = 25,
  parameter int SH2_W   = 33,
  parameter int SPH_W   = 54,
  parameter int MET_W   = 73,
  parameter int GUESS_W = 8
) (
  input  logic                     clk,
  input  logic                     eval,
  input  logic                     first,
  input  logic [GUESS_W-1:0]       guess,
  input  logic [CNT_W-1:0]         n,
  input  logic signed [SP_W-1:0]   sp,
  input  logic [SH_W-1:0]          sh,
  input  logic [SH2_W-1:0]         sh2,
  input  logic signed [SPH_W-1:0]  sph,
  output logic [GUESS_W-1:0]       best_guess,
  output logic signed [MET_W-1:0]  best_metric,
  output logic [SH_W-1:0]          best_sh,
  output logic [SH2_W-1:0]         best_sh2,
  output logic signed [SPH_W-1:0]  best_sph
);

  logic signed [MET_W-1:0] n_x, sph_x, sp_x, sh_x, metric;

  always_comb begin
    n_x    = {{(MET_W-CNT_W){1'b0}}, n};
    sph_x  = {{(MET_W-SPH_W){sph[SPH_W-1]}}, sph};
    sp_x   = {{(MET_W-SP_W){sp[SP_W-1]}}, sp};
    sh_x   = {{(MET_W-SH_W){1'b0}}, sh};
    metric = (n_x * sph_x) - (sp_x * sh_x);
  end

  // strict less-than keeps the lower index on equal metrics
  always_ff @(posedge clk) begin
    if (eval && (first || (metric < best_metric))) begin
      best_guess  <= guess;
      best_metric <= metric;
      best_sh     <= sh;
      best_sh2    <= sh2;
      best_sph    <= sph;
    end
  end

endmodule

// File: rtl/trace_corr_accum.sv
module trace_corr_accum
  import trace_corr_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LEN_LG   = 16,
  parameter int TRACE_LG = 17,
  parameter int HYP_W    = 8,
  parameter int GUESS_W  = 8,
  parameter int CT_W     = 8,
  localparam int SUM_W   = SAMPLE_W + LEN_LG,
  localparam int CNT_W   = TRACE_LG,
  localparam int SP_W    = SUM_W + CNT_W,
  localparam int SP2_W   = 2 * SUM_W + CNT_W,
  localparam int SH_W    = HYP_W + CNT_W,
  localparam int SH2_W   = 2 * HYP_W + CNT_W,
  localparam int SPH_W   = SUM_W + HYP_W + 1 + CNT_W,
  localparam int MET_W   = CNT_W + SPH_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic [SAMPLE_W-1:0]      s_data,
  input  logic                     s_first,
  input  logic                     s_last,
  input  logic [CT_W-1:0]          s_ct,
  output logic                     hyp_req_valid,
  output logic [GUESS_W-1:0]       hyp_req_guess,
  output logic [CT_W-1:0]          hyp_req_ct,
  input  logic                     hyp_rsp_valid,
  input  logic [HYP_W-1:0]         hyp_rsp_value,
  input  logic                     ckpt_req,
  output logic                     ckpt_done,
  output logic [GUESS_W-1:0]       ckpt_guess,
  output logic [MET_W-1:0]         ckpt_metric,
  output logic [CNT_W-1:0]         ckpt_count,
  output logic [SP_W-1:0]          ckpt_sum_p,
  output logic [SP2_W-1:0]         ckpt_sum_p2,
  output logic [SH_W-1:0]          ckpt_sum_h,
  output logic [SH2_W-1:0]         ckpt_sum_h2,
  output logic [SPH_W-1:0]         ckpt_sum_ph
);

  localparam int ROW_W = SPH_W + SH2_W + SH_W;

  acc_state_e               st_q;
  logic [GUESS_W-1:0]       g_q;
  logic [CNT_W-1:0]         n_q;
  logic signed [SP_W-1:0]   sp_q;
  logic [SP2_W-1:0]         sp2_q;
  logic signed [SUM_W-1:0]  p_q;
  logic [CT_W-1:0]          ct_q;
  logic [HYP_W-1:0]         h_q;
  logic                     pend_q;

  // trace folding
  logic                     sum_open, sum_done;
  logic signed [SUM_W-1:0]  sum_val;
  logic [CT_W-1:0]          sum_ct;
  logic                     take;

  assign take = s_valid && s_ready;

  trace_sum_unit #(
    .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W), .CT_W(CT_W)
  ) u_sum (
    .clk(clk), .rst(rst || clr), .take(take), .data(s_data),
    .first(s_first), .last(s_last), .ct(s_ct),
    .open_o(sum_open), .done_o(sum_done), .sum_o(sum_val), .ct_o(sum_ct)
  );

  // per-guess rows
  logic              ram_we;
  logic [ROW_W-1:0]  ram_wdata, ram_rdata;
  logic [SH_W-1:0]   sh_r;
  logic [SH2_W-1:0]  sh2_r;
  logic signed [SPH_W-1:0] sph_r;

  corr_row_ram #(.ADDR_W(GUESS_W), .DATA_W(ROW_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(g_q), .wdata(ram_wdata),
    .raddr(g_q), .rdata(ram_rdata)
  );

  assign {sph_r, sh2_r, sh_r} = ram_rdata;

  // row update arithmetic
  logic signed [SPH_W-1:0] p_h, h_h, sph_new;
  logic [SH_W-1:0]         sh_new;
  logic [SH2_W-1:0]        sh2_new;

  always_comb begin
    p_h     = {{(SPH_W-SUM_W){p_q[SUM_W-1]}}, p_q};
    h_h     = {{(SPH_W-HYP_W){1'b0}}, h_q};
    sph_new = sph_r + (p_h * h_h);
    sh_new  = sh_r + SH_W'(h_q);
    sh2_new = sh2_r + (SH2_W'(h_q) * SH2_W'(h_q));
  end

  assign ram_we    = (st_q == ST_CLR) || (st_q == ST_UWR);
  assign ram_wdata = (st_q == ST_CLR) ? '0 : {sph_new, sh2_new, sh_new};

  // shared-sum update arithmetic
  logic signed [SP_W-1:0]  p_sp;
  logic signed [SP2_W-1:0] p_wide, p_sq;

  always_comb begin
    p_sp   = {{(SP_W-SUM_W){sum_val[SUM_W-1]}}, sum_val};
    p_wide = {{(SP2_W-SUM_W){sum_val[SUM_W-1]}}, sum_val};
    p_sq   = p_wide * p_wide;
  end

  // ranking
  logic [GUESS_W-1:0]       best_g;
  logic signed [MET_W-1:0]  best_m;
  logic [SH_W-1:0]          best_sh;
  logic [SH2_W-1:0]         best_sh2;
  logic signed [SPH_W-1:0]  best_sph;

  corr_rank_unit #(
    .CNT_W(CNT_W), .SP_W(SP_W), .SH_W(SH_W), .SH2_W(SH2_W),
    .SPH_W(SPH_W), .MET_W(MET_W), .GUESS_W(GUESS_W)
  ) u_rank (
    .clk(clk), .eval(st_q == ST_REV), .first(g_q == '0), .guess(g_q),
    .n(n_q), .sp(sp_q), .sh(sh_r), .sh2(sh2_r), .sph(sph_r),
    .best_guess(best_g), .best_metric(best_m), .best_sh(best_sh),
    .best_sh2(best_sh2), .best_sph(best_sph)
  );

  // port drive
  assign s_ready       = (st_q == ST_IDLE) && !sum_done && !(pend_q && !sum_open);
  assign hyp_req_valid = (st_q == ST_UREQ);
  assign hyp_req_guess = g_q;
  assign hyp_req_ct    = ct_q;

  // sequencer
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st_q        <= ST_CLR;
      g_q         <= '0;
      n_q         <= '0;
      sp_q        <= '0;
      sp2_q       <= '0;
      p_q         <= '0;
      ct_q        <= '0;
      h_q         <= '0;
      pend_q      <= 1'b0;
      ckpt_done   <= 1'b0;
      ckpt_guess  <= '0;
      ckpt_metric <= '0;
      ckpt_count  <= '0;
      ckpt_sum_p  <= '0;
      ckpt_sum_p2 <= '0;
      ckpt_sum_h  <= '0;
      ckpt_sum_h2 <= '0;
      ckpt_sum_ph <= '0;
    end else begin
      ckpt_done <= 1'b0;
      if (ckpt_req) pend_q <= 1'b1;
      unique case (st_q)
        ST_CLR: begin
          g_q <= g_q + GUESS_W'(1);
          if (&g_q) st_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (sum_done) begin
            p_q   <= sum_val;
            ct_q  <= sum_ct;
            n_q   <= n_q + CNT_W'(1);
            sp_q  <= sp_q + p_sp;
            sp2_q <= sp2_q + $unsigned(p_sq);
            g_q   <= '0;
            st_q  <= ST_URD;
          end else if (pend_q && !sum_open) begin
            pend_q <= ckpt_req;
            g_q    <= '0;
            st_q   <= ST_RRD;
          end
        end
        ST_URD:  st_q <= ST_UREQ;
        ST_UREQ: begin
          if (hyp_rsp_valid) begin
            h_q  <= hyp_rsp_value;
            st_q <= ST_UWR;
          end
        end
        ST_UWR: begin
          g_q  <= g_q + GUESS_W'(1);
          st_q <= (&g_q) ? ST_IDLE : ST_URD;
        end
        ST_RRD: st_q <= ST_REV;
        ST_REV: begin
          g_q  <= g_q + GUESS_W'(1);
          st_q <= (&g_q) ? ST_RFIN : ST_RRD;
        end
        ST_RFIN: begin
          ckpt_done   <= 1'b1;
          ckpt_guess  <= best_g;
          ckpt_metric <= best_m;
          ckpt_count  <= n_q;
          ckpt_sum_p  <= sp_q;
          ckpt_sum_p2 <= sp2_q;
          ckpt_sum_h  <= best_sh;
          ckpt_sum_h2 <= best_sh2;
          ckpt_sum_ph <= best_sph;
          st_q        <= ST_IDLE;
        end
        default: st_q <= ST_CLR;
      endcase
    end
  end

endmodule

// File: rtl/trace_corr_accum_chk.sv
module trace_corr_accum_chk #(
  parameter int CNT_W   = 17,
  parameter int GUESS_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               clr,
  input logic               s_ready,
  input logic               hyp_req_valid,
  input logic               hyp_rsp_valid,
  input logic [GUESS_W-1:0] hyp_req_guess,
  input logic               ckpt_done,
  input logic [CNT_W-1:0]   trace_cnt
);

  AST_SWEEP_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    hyp_req_valid |-> !s_ready);  // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (hyp_req_valid && !hyp_rsp_valid && !clr) |=> (hyp_req_valid && $stable(hyp_req_guess)));  // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ckpt_done |=> !ckpt_done);  // R7

  AST_DONE_APART_FROM_SWEEP: assert property (@(posedge clk) disable iff (rst)
    ckpt_done |-> !hyp_req_valid);  // R7

  AST_CLEAR_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    clr |=> !s_ready);  // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (trace_cnt != $past(trace_cnt)) |->
      ((trace_cnt == $past(trace_cnt) + CNT_W'(1)) || (trace_cnt == '0)));  // R2

endmodule

bind trace_corr_accum trace_corr_accum_chk #(
  .CNT_W(TRACE_LG), .GUESS_W(GUESS_W)
) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .s_ready(s_ready),
  .hyp_req_valid(hyp_req_valid), .hyp_rsp_valid(hyp_rsp_valid),
  .hyp_req_guess(hyp_req_guess), .ckpt_done(ckpt_done), .trace_cnt(n_q)
);

// File: tb/trace_corr_accum_test.sv
`timescale 1ns/1ps
module trace_corr_accum_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0;
  logic [11:0] s_data = '0;
  logic [7:0]  s_ct = '0;
  logic s_ready;
  logic hyp_req_valid;
  logic [7:0] hyp_req_guess, hyp_req_ct;
  logic hyp_rsp_valid = 1'b0;
  logic [7:0] hyp_rsp_value = '0;
  logic ckpt_req = 1'b0;
  logic ckpt_done;
  logic [7:0]  ckpt_guess;
  logic [72:0] ckpt_metric;
  logic [16:0] ckpt_count;
  logic [44:0] ckpt_sum_p;
  logic [72:0] ckpt_sum_p2;
  logic [24:0] ckpt_sum_h;
  logic [32:0] ckpt_sum_h2;
  logic [53:0] ckpt_sum_ph;

  always #4 clk = ~clk;

  trace_corr_accum uut (
    .clk(clk), .rst(rst), .clr(clr),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_first(s_first), .s_last(s_last), .s_ct(s_ct),
    .hyp_req_valid(hyp_req_valid), .hyp_req_guess(hyp_req_guess),
    .hyp_req_ct(hyp_req_ct), .hyp_rsp_valid(hyp_rsp_valid),
    .hyp_rsp_value(hyp_rsp_value), .ckpt_req(ckpt_req),
    .ckpt_done(ckpt_done), .ckpt_guess(ckpt_guess),
    .ckpt_metric(ckpt_metric), .ckpt_count(ckpt_count),
    .ckpt_sum_p(ckpt_sum_p), .ckpt_sum_p2(ckpt_sum_p2),
    .ckpt_sum_h(ckpt_sum_h), .ckpt_sum_h2(ckpt_sum_h2),
    .ckpt_sum_ph(ckpt_sum_ph)
  );

  int vectors = 0;
  int miscompares = 0;

  // reference model
  longint e_n, e_sp, e_sp2;
  longint e_sh[256], e_sh2[256], e_sph[256];
  bit [7:0] exp_g = '0;
  logic [7:0] exp_ct = '0;

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int hfun(input logic [7:0] c, input logic [7:0] g);
    return $countones(c ^ g) + int'(g[1:0]);
  endfunction

  function automatic int smp(input int i, input int seed, input logic [7:0] c, input int mode);
    if (mode == 1) return -2048;
    if (mode == 2) return 2047;
    return ((i * 73 + seed * 131) % 201) - 100 - 40 * hfun(c, 8'h5A);
  endfunction

  task automatic model_clear();
    e_n = 0; e_sp = 0; e_sp2 = 0;
    for (int g = 0; g < 256; g++) begin
      e_sh[g] = 0; e_sh2[g] = 0; e_sph[g] = 0;
    end
  endtask

  task automatic model_trace(input longint p, input logic [7:0] c);
    e_n++; e_sp += p; e_sp2 += p * p;
    for (int g = 0; g < 256; g++) begin
      longint h = longint'(hfun(c, 8'(g)));
      e_sh[g] += h; e_sh2[g] += h * h; e_sph[g] += p * h;
    end
  endtask

  // hypothesis responder; also checks request order (R3)
  initial begin
    forever begin
      @(negedge clk);
      if (hyp_req_valid && !hyp_rsp_valid) begin
        chk("R3", "request guess", 128'(hyp_req_guess), 128'(exp_g));
        chk("R3", "request ct", 128'(hyp_req_ct), 128'(exp_ct));
        exp_g++;
        hyp_rsp_valid = 1'b1;
        hyp_rsp_value = 8'(hfun(hyp_req_ct, hyp_req_guess));
      end else begin
        hyp_rsp_valid = 1'b0;
      end
    end
  end

  task automatic push(input int v, input bit f, input bit l, input logic [7:0] c);
    do @(negedge clk); while (!s_ready);
    s_valid = 1'b1; s_data = v[11:0]; s_first = f; s_last = l; s_ct = c;
    @(posedge clk); #1;
    s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0;
  endtask

  task automatic send_trace(input int len, input int seed, input logic [7:0] c,
                            input int mode, input int ckpt_at, output longint p);
    p = 0;
    exp_ct = c;
    for (int i = 0; i < len; i++) begin
      int v = smp(i, seed, c, mode);
      if (i == ckpt_at) ckpt_req = 1'b1;
      push(v, i == 0, i == len - 1, c);
      ckpt_req = 1'b0;
      p += longint'(v);
    end
    @(negedge clk);
    chk("R5", "ready after closing beat", 128'(s_ready), 128'(0));
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!s_ready);
  endtask

  task automatic check_report(input string tag);
    longint best = 0;
    int bg = 0;
    for (int g = 0; g < 256; g++) begin
      longint m = e_n * e_sph[g] - e_sp * e_sh[g];
      if (g == 0 || m < best) begin best = m; bg = g; end
    end
    $display("report %s: guess %0d", tag, bg);
    chk("R6", "best guess", 128'(ckpt_guess), 128'(bg));
    chk("R6", "best metric", $signed(ckpt_metric), best);
    chk("R2", "trace count", 128'(ckpt_count), e_n);
    chk("R1", "sum of P", $signed(ckpt_sum_p), e_sp);
    chk("R2", "sum of P squared", 128'(ckpt_sum_p2), e_sp2);
    chk("R4", "sum H", 128'(ckpt_sum_h), e_sh[bg]);
    chk("R4", "sum H squared", 128'(ckpt_sum_h2), e_sh2[bg]);
    chk("R4", "sum PH", $signed(ckpt_sum_ph), e_sph[bg]);
    @(negedge clk);
    chk("R7", "done single cycle", 128'(ckpt_done), 128'(0));
  endtask

  task automatic wait_report(input string tag);
    do @(negedge clk); while (!ckpt_done);
    check_report(tag);
  endtask

  task automatic do_ckpt(input string tag);
    @(negedge clk);
    ckpt_req = 1'b1;
    @(posedge clk); #1;
    ckpt_req = 1'b0;
    wait_report(tag);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    longint p;
    model_clear();
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R8", "ready during clear", 128'(s_ready), 128'(0));
    chk("R7", "done after reset", 128'(ckpt_done), 128'(0));
    wait_idle();

    // empty statistics: all metrics tie at zero, guess 0 wins
    do_ckpt("empty");

    // one-beat trace
    send_trace(1, 1, 8'h3C, 0, -1, p);
    wait_idle(); model_trace(p, 8'h3C);
    do_ckpt("single beat");

    // stray beats then a restarted trace (R9)
    push(500, 1'b0, 1'b0, 8'h00);
    push(-700, 1'b0, 1'b0, 8'h00);
    push(300, 1'b0, 1'b1, 8'h00);
    push(1000, 1'b1, 1'b0, 8'h00);
    for (int i = 0; i < 5; i++) push(900, 1'b0, 1'b0, 8'h00);
    send_trace(50, 2, 8'hC7, 0, -1, p);
    wait_idle(); model_trace(p, 8'hC7);
    do_ckpt("R9 restart");

    // varied traces
    for (int t = 0; t < 6; t++) begin
      logic [7:0] c = 8'(t * 53 + 7);
      send_trace(20 + t * 37, t + 3, c, 0, -1, p);
      wait_idle(); model_trace(p, c);
      if (t % 2 == 1) do_ckpt("varied");
    end

    // checkpoint raised while a trace is open is deferred behind it
    send_trace(60, 9, 8'hA5, 0, 30, p);
    model_trace(p, 8'hA5);
    wait_report("deferred");

    // extreme sample values
    send_trace(3000, 0, 8'h11, 1, -1, p);
    wait_idle(); model_trace(p, 8'h11);
    send_trace(2000, 0, 8'hF0, 2, -1, p);
    wait_idle(); model_trace(p, 8'hF0);
    do_ckpt("extremes");

    // synchronous clear
    @(negedge clk);
    clr = 1'b1;
    @(posedge clk); #1;
    clr = 1'b0;
    @(negedge clk);
    chk("R8", "ready after clear", 128'(s_ready), 128'(0));
    wait_idle();
    model_clear();
    exp_g = '0;
    do_ckpt("R8 cleared");

    send_trace(77, 5, 8'h5A, 0, -1, p);
    wait_idle(); model_trace(p, 8'h5A);
    do_ckpt("after clear");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule